// File: doc/BRIEF.md
# Channel-Enable Configuration Port with Deferred Activation

This block is the device-side digital port of a multi-channel sampling converter. A host writes an 8-bit channel-enable word over a strobe bus made of an active-low chip select and an active-low write strobe. The word lands in a pending register. A second, active register drives the channel mask seen by the conversion logic. The active register copies the pending one only when a conversion is started, which is a falling edge on the active-low start input. The host can therefore rewrite the enables at any moment, including in the middle of a conversion, without disturbing the channels in use.

The same port returns a 12-bit conversion result. While chip select and read are both low, all twelve output enables are on and the result word from a stub input is driven. Bus lines 0 to 7 also carry write data inward. Lines 8 to 11 only drive outward, so the input side of the bus is 8 bits wide. The write strobe and the start input are asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops before its edge is detected in the system clock domain. Write data and chip select are delayed by the same number of stages, so the captured word is the one that was present while the strobe was still low. The block has no valid/ready stream. The host bus is strobe-timed and gives no back-pressure, and the result path is a plain combinational drive.

Top module: `chan_cfg_bus`

## Requirements
- R1: After reset both registers hold all ones, so `chan_mask` shows `NUM_CH` low bits set.
- R2: A write happens on a rising edge of `wr_n` while `cs_n` is low. It captures `bus_in[7:0]` as held during the last low-strobe sample. A rising edge of `wr_n` while `cs_n` is high changes nothing.
- R3: A written word does not change `chan_mask` until the next falling edge of `conv_start_n`. After that edge, `chan_mask` changes `SYNC_STAGES` clock edges after the edge is first sampled.
- R4: Bit n of the word enables channel n, where 1 means active. For n at or above `NUM_CH` (8, 4 or 2), `chan_mask[n]` is always 0.
- R5: `shdn` neither clears nor blocks either register. Writes taken during shutdown activate normally.
- R6: A write made while a conversion is in progress (`conv_start_n` held low) does not affect the mask until the next falling edge of `conv_start_n`.
- R7: If a write edge and a start edge are detected in the same clock cycle, the mask takes the word just written.
- R8: While `cs_n` and `rd_n` are both low, `bus_oe` is 12'hFFF and `bus_out` equals `result_in`. Otherwise `bus_oe` is 0.
- R9: A rising edge of `conv_start_n`, or a repeated start with no write in between, leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, data taken on its rise |
| conv_start_n | input | 1 | Conversion start, active low, falling edge activates |
| shdn | input | 1 | Shutdown request, has no effect on the registers |
| bus_in | input | 8 | Inbound data on bus lines 0 to 7 |
| bus_out | output | 12 | Outbound data bus |
| bus_oe | output | 12 | Per-line output enable |
| result_in | input | 12 | Conversion result stub |
| chan_mask | output | 8 | Active channel mask to the conversion logic |

## Verification
The read path is combinational, so `bus_oe` and `bus_out` are checked half a cycle after the strobes change. A strobe edge takes `SYNC_STAGES` clock edges to act on a register. The bench therefore changes inputs on falling clock edges, holds each level for `SYNC_STAGES`+3 cycles, and samples the mask only after that settling window. Before each start it also checks that a new write has not yet reached the mask. An exhaustive sweep of all 256 words runs through an 8-channel and a 4-channel instance side by side, and the expected masks are computed as the word ANDed with the lane mask.

// File: rtl/chcfg_pkg.sv
package chcfg_pkg;
  localparam int CFG_W = 8;
  localparam int BUS_W = 12;

  function automatic logic [CFG_W-1:0] lane_mask(input int n);
    logic [CFG_W-1:0] m;
    for (int i = 0; i < CFG_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/chcfg_sync_edge.sv
module chcfg_sync_edge #(
  parameter int   STAGES  = 2,
  parameter bit   RISING  = 1'b1,
  parameter logic IDLE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic hit
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {(STAGES+1){IDLE}};
    else        sh <= {sh[STAGES-1:0], sig_in};
  end

  generate
    if (RISING) begin : g_rise
      assign hit = sh[STAGES-1] & ~sh[STAGES];
    end else begin : g_fall
      assign hit = ~sh[STAGES-1] & sh[STAGES];
    end
  endgenerate

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/chcfg_delay.sv
module chcfg_delay #(
  parameter int DEPTH = 3,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out
);
  logic [DEPTH-1:0][DW-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else begin
      pipe[0] <= d_in;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign d_out = pipe[DEPTH-1];
endmodule

// File: rtl/chcfg_regs.sv
module chcfg_regs
  import chcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [CFG_W-1:0] wdata,
  input  logic             cv_fire,
  output logic [CFG_W-1:0] active
);
  logic [CFG_W-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '1;
      active  <= '1;
    end else begin
      if (wr_fire) pending <= wdata;
      if (cv_fire) active  <= wr_fire ? wdata : pending;
    end
  end

  a_r3_hold_between_starts: assert property (@(posedge clk) disable iff (!rst_n)
    !cv_fire |=> $stable(active));
  a_r3_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_fire && !wr_fire) |=> active == $past(pending));
  a_r7_same_cycle_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_fire && wr_fire) |=> active == $past(wdata));
  a_r2_pending_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(pending));
endmodule

// File: rtl/chcfg_bus_drive.sv
module chcfg_bus_drive
  import chcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [BUS_W-1:0] result_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe
);
  logic rd_en;

  assign rd_en   = ~cs_n & ~rd_n;
  assign bus_oe  = {BUS_W{rd_en}};
  assign bus_out = rd_en ? result_in : '0;

  a_r8_oe_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bus_oe) == 0) || ($countones(bus_oe) == BUS_W));
  a_r8_steady_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe[0] && $past(bus_oe[0]) && $stable(result_in)) |-> $stable(bus_out));
endmodule

// File: rtl/chan_cfg_bus.sv
module chan_cfg_bus
  import chcfg_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             conv_start_n,
  input  logic             shdn,
  input  logic [CFG_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe,
  input  logic [BUS_W-1:0] result_in,
  output logic [CFG_W-1:0] chan_mask
);
  localparam logic [CFG_W-1:0] LANES = lane_mask(NUM_CH);
  localparam int               SIDE_W = CFG_W + 1;

  logic              wr_rise, cv_fall, wr_fire;
  logic [SIDE_W-1:0] side_d;
  logic [CFG_W-1:0]  active;

  chcfg_sync_edge #(.STAGES(SYNC_STAGES), .RISING(1'b1), .IDLE(1'b1)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .sig_in(wr_n), .hit(wr_rise));

  chcfg_sync_edge #(.STAGES(SYNC_STAGES), .RISING(1'b0), .IDLE(1'b1)) u_cv_sync (
    .clk(clk), .rst_n(rst_n), .sig_in(conv_start_n), .hit(cv_fall));

  chcfg_delay #(.DEPTH(SYNC_STAGES + 1), .DW(SIDE_W)) u_side (
    .clk(clk), .rst_n(rst_n), .d_in({cs_n, bus_in}), .d_out(side_d));

  assign wr_fire = wr_rise & ~side_d[CFG_W];

  chcfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wdata(side_d[CFG_W-1:0]),
    .cv_fire(cv_fall), .active(active));

  chcfg_bus_drive u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .result_in(result_in), .bus_out(bus_out), .bus_oe(bus_oe));

  generate
    for (genvar i = 0; i < CFG_W; i++) begin : g_lane
      if (LANES[i]) begin : g_on
        assign chan_mask[i] = active[i];
      end else begin : g_off
        assign chan_mask[i] = 1'b0;
      end
    end
  endgenerate

  a_r5_shdn_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn && !cv_fall) |=> $stable(chan_mask));
  a_r4_unused_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mask & ~LANES) == '0);
endmodule

// File: tb/chan_cfg_bus_tb.sv
module chan_cfg_bus_tb;
  localparam int SYNC = 2;
  localparam int WAITN = SYNC + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cv_n = 1'b1, shdn = 1'b0;
  logic [7:0] bus_in = '0;
  logic [11:0] result_in = '0;
  logic [11:0] out8, oe8, out4, oe4;
  logic [7:0] m8, m4;
  int total = 0, bad = 0;
  logic [7:0] cur;

  always #5 clk = ~clk;

  chan_cfg_bus #(.NUM_CH(8), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .conv_start_n(cv_n), .shdn(shdn), .bus_in(bus_in), .bus_out(out8),
    .bus_oe(oe8), .result_in(result_in), .chan_mask(m8));

  chan_cfg_bus #(.NUM_CH(4), .SYNC_STAGES(SYNC)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .conv_start_n(cv_n), .shdn(shdn), .bus_in(bus_in), .bus_out(out4),
    .bus_oe(oe4), .result_in(result_in), .chan_mask(m4));

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] v, input logic sel_n);
    cs_n = sel_n; bus_in = v; wr_n = 1'b0;
    ticks(2);
    wr_n = 1'b1;
    ticks(WAITN);
    cs_n = 1'b1; bus_in = ~v;
    ticks(1);
  endtask

  task automatic do_start();
    cv_n = 1'b0;
    ticks(WAITN);
    cv_n = 1'b1;
    ticks(WAITN);
  endtask

  task automatic chk_mask(input string req, input logic [7:0] e);
    chk(req, {4'h0, m8}, {4'h0, e});
    chk(req, {4'h0, m4}, {8'h0, e[3:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(2);
    cur = 8'hFF;
    chk_mask("R1_reset", 8'hFF);
    chk("R8_idle_oe", oe8, 12'h000);

    // R8 read path
    result_in = 12'hA5C; cs_n = 1'b0; rd_n = 1'b0;
    ticks(1);
    chk("R8_oe", oe8, 12'hFFF);
    chk("R8_out", out8, 12'hA5C);
    result_in = 12'h3F1;
    ticks(1);
    chk("R8_out2", out8, 12'h3F1);
    cs_n = 1'b1;
    ticks(1);
    chk("R8_cs_high", oe8, 12'h000);
    cs_n = 1'b0; rd_n = 1'b1;
    ticks(1);
    chk("R8_rd_high", oe8, 12'h000);
    cs_n = 1'b1;
    ticks(1);

    // R2/R3/R4/R5 sweep of every word, shutdown toggled by bit 2
    for (int v = 0; v < 256; v++) begin
      shdn = v[2];
      do_write(v[7:0], 1'b0);
      chk_mask("R3_before_start", cur);
      do_start();
      cur = v[7:0];
      chk_mask(shdn ? "R5_write_in_shdn" : "R2_R4_sweep", cur);
    end
    shdn = 1'b0;

    // R2 write ignored with chip select high
    do_write(8'h3C, 1'b1);
    do_start();
    chk_mask("R2_cs_high_ignored", cur);

    // R6 write during conversion, R9 rising start edge
    do_write(8'h5A, 1'b0);
    do_start();
    cur = 8'h5A;
    cv_n = 1'b0;
    ticks(WAITN);
    do_write(8'h11, 1'b0);
    chk_mask("R6_mid_conv_hold", cur);
    cv_n = 1'b1;
    ticks(WAITN);
    chk_mask("R9_rise_no_effect", cur);
    do_start();
    cur = 8'h11;
    chk_mask("R6_next_start", cur);

    // R9 repeated start without write
    do_start();
    chk_mask("R9_repeat_start", cur);

    // R7 simultaneous write and start edges
    cs_n = 1'b0; bus_in = 8'hC6; wr_n = 1'b0;
    ticks(2);
    wr_n = 1'b1; cv_n = 1'b0;
    ticks(WAITN);
    chk_mask("R7_same_cycle", 8'hC6);
    cv_n = 1'b1; cs_n = 1'b1;
    ticks(WAITN);

    // R1 reset again restores all ones
    rst_n = 1'b0;
    ticks(2);
    rst_n = 1'b1;
    ticks(2);
    chk_mask("R1_rereset", 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule